// File: doc/BRIEF.md
# Impedance Calibration Update Scheduler

This controller sits between a device's decoded command stream and an abstract impedance calibration engine. The engine presents a candidate driver impedance code along with a done flag. The scheduler copies that code into the driver output register only in cycles where the copy cannot disturb a transfer. Those cycles are an auto-refresh command, or an idle (NOP) command when no read burst is outstanding. Commands are never held back, because the scheduler only observes the command stream.

The scheduler also counts a power-up calibration interval. The interval is a parameterised number of clock cycles, derived from the clock rate and a duration in microseconds. It starts once the clock is reported stable, and a flag shows when it has elapsed. Until the flag rises, the impedance is not yet guaranteed to be optimal. Two termination ratio selections are captured during an init phase and then frozen until reset. One is for the address/command pins and one is for the data pins.

Top module: `zq_update_sched`

## Requirements
- R1: After reset, drv_code_o equals RST_CODE, and upd_strobe_o, cal_ready_o, read_busy_o, ca_term_o and dq_term_o are all 0.
- R2: Command encoding on cmd_i is 0 NOP, 1 READ, 2 WRITE, 3 AUTO REFRESH, 4..7 other. A READ makes read_busy_o high from the next cycle for READ_LAT + 2 cycles when burst_len_i is 0 (burst of 4), or READ_LAT + 4 cycles when burst_len_i is 1 (burst of 8).
- R3: An AUTO REFRESH sampled with cal_done_i high loads cal_code_i into drv_code_o on that edge. The same edge raises upd_strobe_o for exactly one cycle. This happens whether or not a read is outstanding.
- R4: A NOP with cal_done_i high performs the same update only when read_busy_o is low in that cycle. A NOP while read_busy_o is high leaves drv_code_o unchanged and upd_strobe_o low.
- R5: READ, WRITE and codes 4..7 never change drv_code_o and never raise upd_strobe_o.
- R6: With cal_done_i low, no command changes drv_code_o or raises upd_strobe_o.
- R7: cal_ready_o rises after CAL_CYCLES = CLK_HZ/1e6 × CAL_US consecutive edges with clk_stable_i high, and then stays high. A cycle with clk_stable_i low clears it from the next cycle and restarts the count.
- R8: While init_i is high and has not yet fallen since reset, ca_term_o follows ca_sel_i (0 = half of reference, 1 = full reference) and dq_term_o follows dq_sel_i (0 = quarter, 1 = half), each one cycle later. After init_i first falls, both are frozen until reset.
- R9: A READ that arrives while read_busy_o is high restarts the busy window with the length set by its own burst_len_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clk_stable_i | input | 1 | Clock reported stable |
| cmd_i | input | 3 | Decoded command |
| burst_len_i | input | 1 | Burst length of a READ: 0 = 4, 1 = 8 |
| cal_code_i | input | CODE_W | Candidate code from calibration engine |
| cal_done_i | input | 1 | Candidate code valid |
| init_i | input | 1 | Init phase, termination selections captured |
| ca_sel_i | input | 1 | Address/command termination ratio selection |
| dq_sel_i | input | 1 | Data termination ratio selection |
| drv_code_o | output | CODE_W | Applied driver impedance code |
| upd_strobe_o | output | 1 | Pulse: code applied on the last edge |
| cal_ready_o | output | 1 | Power-up calibration interval elapsed |
| read_busy_o | output | 1 | Read burst outstanding |
| ca_term_o | output | 1 | Latched address/command ratio |
| dq_term_o | output | 1 | Latched data ratio |

## Verification
Several things can land on the same edge. A read can be starting or still outstanding while a NOP or auto-refresh arrives with a fresh calibration code. The power-up count can also cross its limit, or be cleared, on an edge where an update fires. The stimulus mixes pseudo-random commands, done flags and burst lengths, and inserts back-to-back reads. It also drops clk_stable_i partway through the run, so these overlaps occur many times. A behavioural model in the bench predicts every output on every cycle. Each compare is tagged with the rule that governs the command that caused it.

// File: rtl/zq_pkg.sv
package zq_pkg;
  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_READ  = 3'd1,
    CMD_WRITE = 3'd2,
    CMD_AREF  = 3'd3,
    CMD_ACT   = 3'd4,
    CMD_PRE   = 3'd5,
    CMD_MRS   = 3'd6,
    CMD_DESEL = 3'd7
  } cmd_e;
endpackage

// File: rtl/zq_pwrup_timer.sv
module zq_pwrup_timer #(
  parameter int unsigned CAL_CYCLES = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stable_i,
  output logic ready_o
);
  localparam int unsigned CW = $clog2(CAL_CYCLES + 1);
  localparam logic [CW-1:0] LIM = CW'(CAL_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!stable_i)   cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign ready_o = (cnt_q == LIM);

  p_cnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIM);
  p_unstable_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stable_i |=> !ready_o);
endmodule

// File: rtl/zq_read_tracker.sv
module zq_read_tracker #(
  parameter int unsigned READ_LAT  = 5,
  parameter int unsigned BL_SHORT  = 4,
  parameter int unsigned BL_LONG   = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic read_i,
  input  logic long_i,
  output logic busy_o
);
  localparam int unsigned SHORT_WIN = READ_LAT + BL_SHORT / 2;
  localparam int unsigned LONG_WIN  = READ_LAT + BL_LONG / 2;
  localparam int unsigned CW        = $clog2(LONG_WIN + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (read_i)        cnt_q <= long_i ? CW'(LONG_WIN) : CW'(SHORT_WIN);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  p_busy_after_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    read_i |=> busy_o);
  p_busy_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(LONG_WIN));
endmodule

// File: rtl/zq_term_latch.sv
module zq_term_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic ca_sel_i,
  input  logic dq_sel_i,
  output logic ca_o,
  output logic dq_o
);
  logic locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      ca_o     <= 1'b0;
      dq_o     <= 1'b0;
    end else begin
      locked_q <= locked_q | ~init_i;
      if (init_i && !locked_q) begin
        ca_o <= ca_sel_i;
        dq_o <= dq_sel_i;
      end
    end
  end

  p_term_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> ($stable(ca_o) && $stable(dq_o)));
endmodule

// File: rtl/zq_update_sched.sv
module zq_update_sched
  import zq_pkg::*;
#(
  parameter int unsigned CODE_W   = 6,
  parameter logic [CODE_W-1:0] RST_CODE = CODE_W'(32),
  parameter int unsigned CLK_HZ   = 100_000_000,
  parameter int unsigned CAL_US   = 20,
  parameter int unsigned READ_LAT = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_stable_i,
  input  logic [2:0]        cmd_i,
  input  logic              burst_len_i,
  input  logic [CODE_W-1:0] cal_code_i,
  input  logic              cal_done_i,
  input  logic              init_i,
  input  logic              ca_sel_i,
  input  logic              dq_sel_i,
  output logic [CODE_W-1:0] drv_code_o,
  output logic              upd_strobe_o,
  output logic              cal_ready_o,
  output logic              read_busy_o,
  output logic              ca_term_o,
  output logic              dq_term_o
);
  localparam int unsigned CAL_CYCLES = (CLK_HZ / 1_000_000) * CAL_US;

  cmd_e cmd;
  logic permit, apply;

  assign cmd = cmd_e'(cmd_i);

  zq_pwrup_timer #(.CAL_CYCLES(CAL_CYCLES)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .stable_i(clk_stable_i), .ready_o(cal_ready_o)
  );

  zq_read_tracker #(.READ_LAT(READ_LAT)) u_rd (
    .clk_i(clk_i), .rst_ni(rst_ni), .read_i(cmd == CMD_READ),
    .long_i(burst_len_i), .busy_o(read_busy_o)
  );

  zq_term_latch u_term (
    .clk_i(clk_i), .rst_ni(rst_ni), .init_i(init_i),
    .ca_sel_i(ca_sel_i), .dq_sel_i(dq_sel_i), .ca_o(ca_term_o), .dq_o(dq_term_o)
  );

  // refresh always safe; idle only outside a read burst
  assign permit = (cmd == CMD_AREF) || (cmd == CMD_NOP && !read_busy_o);
  assign apply  = permit && cal_done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drv_code_o   <= RST_CODE;
      upd_strobe_o <= 1'b0;
    end else begin
      upd_strobe_o <= apply;
      if (apply) drv_code_o <= cal_code_i;
    end
  end

  p_code_hold_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (read_busy_o && cmd_i != 3'd3) |=> $stable(drv_code_o));
  p_no_update_other_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i != 3'd0 && cmd_i != 3'd3) |=> !upd_strobe_o);
  p_strobe_needs_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cal_done_i |=> (!upd_strobe_o && $stable(drv_code_o)));
  p_aref_applies_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd3 && cal_done_i) |=> (upd_strobe_o && drv_code_o == $past(cal_code_i)));
endmodule

// File: tb/zq_update_sched_tb.sv
module zq_update_sched_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CODE_W     = 6;
  localparam int RL         = 5;
  localparam int CAL_CYC    = 2000;
  localparam int NCYC       = 3400;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic clk_stable_i = 0, burst_len_i = 0, cal_done_i = 0, init_i = 1, ca_sel_i = 0, dq_sel_i = 0;
  logic [2:0] cmd_i = 3'd0;
  logic [CODE_W-1:0] cal_code_i = '0;
  logic [CODE_W-1:0] drv_code_o;
  logic upd_strobe_o, cal_ready_o, read_busy_o, ca_term_o, dq_term_o;

  int n_chk = 0, n_fail = 0;

  // reference model state
  int m_code = 32, m_strobe = 0, m_busy = 0, m_cnt = 0, m_ca = 0, m_dq = 0, m_lock = 0;
  string tag_upd = "R1", tag_busy = "R1";

  zq_update_sched u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .clk_stable_i(clk_stable_i), .cmd_i(cmd_i),
    .burst_len_i(burst_len_i), .cal_code_i(cal_code_i), .cal_done_i(cal_done_i),
    .init_i(init_i), .ca_sel_i(ca_sel_i), .dq_sel_i(dq_sel_i), .drv_code_o(drv_code_o),
    .upd_strobe_o(upd_strobe_o), .cal_ready_o(cal_ready_o), .read_busy_o(read_busy_o),
    .ca_term_o(ca_term_o), .dq_term_o(dq_term_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_code = 32; m_strobe = 0; m_busy = 0; m_cnt = 0; m_ca = 0; m_dq = 0; m_lock = 0;
    end else begin
      bit ok;
      ok = (cmd_i == 3) || (cmd_i == 0 && m_busy == 0);
      if (!cal_done_i) tag_upd = "R6";
      else if (cmd_i == 3) tag_upd = "R3";
      else if (cmd_i == 0) tag_upd = "R4";
      else tag_upd = "R5";
      m_strobe = (ok && cal_done_i) ? 1 : 0;
      if (m_strobe == 1) m_code = cal_code_i;
      if (cmd_i == 1) begin
        tag_busy = (m_busy > 0) ? "R9" : "R2";
        m_busy = RL + (burst_len_i ? 4 : 2);
      end else begin
        tag_busy = "R2";
        if (m_busy > 0) m_busy--;
      end
      if (!clk_stable_i) m_cnt = 0;
      else if (m_cnt < CAL_CYC) m_cnt++;
      if (init_i && m_lock == 0) begin m_ca = ca_sel_i; m_dq = dq_sel_i; end
      if (!init_i) m_lock = 1;
    end
  end

  initial begin : wdog
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : stim
    logic [31:0] lf;
    lf = 32'h1ACE_B00C;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "drv_code", drv_code_o, 32);
    check("R1", "strobe", upd_strobe_o, 0);
    check("R1", "ready", cal_ready_o, 0);
    check("R1", "busy", read_busy_o, 0);
    check("R1", "ca_term", ca_term_o, 0);
    check("R1", "dq_term", dq_term_o, 0);
    rst_ni = 1'b1;
    for (int k = 0; k < NCYC; k++) begin
      @(negedge clk);
      if (k > 0) begin
        check(tag_upd, "drv_code", drv_code_o, m_code);
        check(tag_upd, "strobe", upd_strobe_o, m_strobe);
        check(tag_busy, "busy", read_busy_o, (m_busy > 0) ? 1 : 0);
        check("R7", "ready", cal_ready_o, (m_cnt == CAL_CYC) ? 1 : 0);
        check("R8", "ca_term", ca_term_o, m_ca);
        check("R8", "dq_term", dq_term_o, m_dq);
      end
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      init_i       = (k < 20);
      ca_sel_i     = lf[3];
      dq_sel_i     = lf[4];
      clk_stable_i = (k >= 5) && !(k >= 1000 && k < 1004);
      cal_code_i   = lf[10:5];
      cal_done_i   = lf[11] | lf[12];
      burst_len_i  = lf[13];
      if (k >= 20 && k < 40) cmd_i = (k % 3 == 0) ? 3'd1 : 3'd0;  // back-to-back reads
      else if (lf[16:14] == 3'd0 || lf[16:14] == 3'd5) cmd_i = 3'd1;
      else if (lf[16:14] == 3'd7) cmd_i = 3'd3;
      else if (lf[16:14] == 3'd6) cmd_i = lf[19:17];
      else cmd_i = 3'd0;
    end
    @(negedge clk);
    check("R7", "ready_end", cal_ready_o, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule